// File: doc/BRIEF.md
# Floating-Point Exception Status and Trap-Enable Register

This block holds the 64-bit control and status word of a floating-point unit. The low six bits are a trap-disable mask that applies to every operation. Above the mask are four status fields of 13 bits each. Field 0 is the default field. Fields 1 to 3 are alternates that an operation can pick. Each field carries its own rounding, precision, flush-to-zero and widest-range-exponent controls. It also carries six sticky exception flags and a per-field trap-disable bit. In field 0 that per-field bit is reserved.

An arithmetic unit reports the exceptions of one finished operation through a valid strobe, a 2-bit field selector and six raw exception bits. In the same cycle the block tells the pipeline whether a fault or a trap must be taken. On the next clock edge it ORs the reported bits into the selected field's flags. A second input withholds the denormal/unnormal report when the operand took no part in a real calculation, for example when the other operand is a NaN. Software reads the whole word at any time and writes it as a whole.

Top module: `fp_status_reg`

## Requirements
- R1: After reset the word reads 0x0000_0000_0000_003F. All six trap-disable bits are set, and every field control and flag is zero.
- R2: Bits 5:0 are the trap-disable mask. From bit 0 upward the bits cover invalid, denormal/unnormal, zero-divide, overflow, underflow and inexact. A set bit suppresses the request for that exception.
- R3: Field n (n = 0..3) sits at bits 6+13n upward. Inside a field, bit 0 is flush-to-zero, bit 1 is widest-range exponent, bits 3:2 are precision, bits 5:4 are rounding, bit 6 is trap-disable and bits 12:7 are the flags in the mask's order. A software write is visible on the next cycle. Bits 63:58 always read zero.
- R4: A valid report ORs its six bits into the flags of the field named by the selector. The updated flags are readable one cycle after the report.
- R5: Flags are sticky: a report never clears a flag. Only a software write can clear one.
- R6: When a report is valid, fault_req is high in the same cycle if an enabled invalid, denormal or zero-divide bit is set. trap_req is high in the same cycle if an enabled overflow, underflow or inexact bit is set.
- R7: An exception whose mask bit is set raises no request, and its flag is still recorded.
- R8: In fields 1 to 3, a set per-field trap-disable bit suppresses every request for reports to that field. In field 0 that bit ignores writes, reads zero and suppresses nothing.
- R9: A software write that sets flags raises no request. Both request outputs are low whenever no report is valid.
- R10: While the suppress input is high, the reported denormal/unnormal bit neither sets its flag nor raises a fault. The other bits are unaffected.
- R11: When a software write and a report fall in the same cycle, the written value is stored and the report's flag update is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_data | input | 64 | Software write value |
| sw_rd_data | output | 64 | Current register word |
| exc_valid | input | 1 | Exception report valid |
| exc_sel | input | 2 | Status field selected by the operation |
| exc_bits | input | 6 | Raw exception bits, same order as the mask |
| exc_denorm_suppress | input | 1 | Withhold the denormal/unnormal bit of this report |
| fault_req | output | 1 | Enabled invalid, denormal or zero-divide exception |
| trap_req | output | 1 | Enabled overflow, underflow or inexact exception |

## Verification
The bench builds the block with its default of four status fields. This lets every selector value reach a distinct field and places the last field directly below the reserved bits, so a write of all ones checks the reserved-bit masking at the upper boundary. Sweeping the mask one bit at a time with every exception bit raised checks the order of the mask bits and the split between faults and traps. The alternate fields make it possible to compare the per-field disable with the reserved bit of field 0.

// File: rtl/fpstat_pkg.sv
// Package: shared layout constants of the floating-point status word.
// Assumes six exceptions in the fixed order invalid, denormal, zero-divide,
// overflow, underflow, inexact; the first three are faults, the rest traps.
package fpstat_pkg;
    localparam int NUM_EXC   = 6;
    localparam int FTZ_B     = 0;
    localparam int WRE_B     = 1;
    localparam int PREC_LSB  = 2;
    localparam int RND_LSB   = 4;
    localparam int FTD_B     = 6;
    localparam int FLAG_LSB  = 7;
    localparam int FIELD_W   = FLAG_LSB + NUM_EXC;
    localparam int DEN_IDX   = 1;
    localparam logic [NUM_EXC-1:0] FAULT_MASK = 6'b000111;
    localparam logic [NUM_EXC-1:0] TRAP_MASK  = 6'b111000;
endpackage

// File: rtl/fpstat_field.sv
// Module: one status field (controls, per-field trap disable, sticky flags).
// Assumes software write and flag update are never both asserted; the top
// gives the write priority. In the main field the trap-disable bit is reserved.
module fpstat_field
    import fpstat_pkg::*;
#(
    parameter bit IS_MAIN = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_we,
    input  logic [FIELD_W-1:0] sw_val,
    input  logic               upd_en,
    input  logic [NUM_EXC-1:0] upd_flags,
    output logic [FIELD_W-1:0] val
);
    localparam logic [FIELD_W-1:0] ALL1  = {FIELD_W{1'b1}};
    localparam logic [FIELD_W-1:0] TDBIT = FIELD_W'(1) << FTD_B;
    localparam logic [FIELD_W-1:0] WMASK = IS_MAIN ? (ALL1 & ~TDBIT) : ALL1;

    // Field storage: software load, otherwise OR in reported flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val <= '0;
        end else if (sw_we) begin
            val <= sw_val & WMASK;
        end else if (upd_en) begin
            val[FLAG_LSB +: NUM_EXC] <= val[FLAG_LSB +: NUM_EXC] | upd_flags;
        end
    end

    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sw_we) |->
        ((val[FLAG_LSB +: NUM_EXC] & $past(val[FLAG_LSB +: NUM_EXC]))
            == $past(val[FLAG_LSB +: NUM_EXC])));

    // R4
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(upd_en) && !$past(sw_we)) |->
        ((val[FLAG_LSB +: NUM_EXC] & $past(upd_flags)) == $past(upd_flags)));

    generate
        if (IS_MAIN) begin : g_main
            // R8
            main_td_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> !val[FTD_B]);
        end
    endgenerate
endmodule

// File: rtl/fpstat_req.sv
// Module: combinational fault/trap request decode for one report.
// Assumes field_td is already zero for the main field.
module fpstat_req
    import fpstat_pkg::*;
(
    input  logic               exc_valid,
    input  logic [NUM_EXC-1:0] eff_bits,
    input  logic [NUM_EXC-1:0] glob_td,
    input  logic               field_td,
    output logic               fault_req,
    output logic               trap_req
);
    logic [NUM_EXC-1:0] enabled;

    // Exceptions that survive both disable levels.
    always_comb begin
        enabled   = eff_bits & ~glob_td & {NUM_EXC{~field_td}};
        fault_req = exc_valid && |(enabled & FAULT_MASK);
        trap_req  = exc_valid && |(enabled & TRAP_MASK);
    end

    // Request-side sanity checks.
    always_comb begin
        // R9
        no_req_idle_chk: assert (exc_valid || (!fault_req && !trap_req));
        // R8
        field_td_quiet_chk: assert (!field_td || (!fault_req && !trap_req));
        // R7
        mask_all_quiet_chk: assert (!(&glob_td) || (!fault_req && !trap_req));
    end
endmodule

// File: rtl/fp_status_reg.sv
// Module: floating-point status word with global trap-disable mask and
// NUM_FIELDS status fields. Reports update the selected field one cycle
// later; requests are decoded in the report cycle. Software write wins.
module fp_status_reg
    import fpstat_pkg::*;
#(
    parameter int NUM_FIELDS = 4,
    parameter int REG_W      = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sw_wr_en,
    input  logic [REG_W-1:0]              sw_wr_data,
    output logic [REG_W-1:0]              sw_rd_data,
    input  logic                          exc_valid,
    input  logic [$clog2(NUM_FIELDS)-1:0] exc_sel,
    input  logic [NUM_EXC-1:0]            exc_bits,
    input  logic                          exc_denorm_suppress,
    output logic                          fault_req,
    output logic                          trap_req
);
    localparam int SEL_W   = $clog2(NUM_FIELDS);
    localparam int FLD_LSB = NUM_EXC;
    localparam int USED_W  = NUM_EXC + NUM_FIELDS * FIELD_W;

    logic [NUM_EXC-1:0] glob_td;
    logic [FIELD_W-1:0] fval [NUM_FIELDS];
    logic [NUM_EXC-1:0] eff_bits;
    logic               sel_td;

    // Global trap-disable mask register.
    always_ff @(posedge clk) begin
        if (!rst_n) glob_td <= '1;
        else if (sw_wr_en) glob_td <= sw_wr_data[NUM_EXC-1:0];
    end

    // Drop the denormal bit when the operand took no part in arithmetic.
    always_comb begin
        eff_bits = exc_bits;
        if (exc_denorm_suppress) eff_bits[DEN_IDX] = 1'b0;
    end

    genvar g;
    generate
        for (g = 0; g < NUM_FIELDS; g++) begin : g_fld
            fpstat_field #(.IS_MAIN(g == 0)) u_field (
                .clk       (clk),
                .rst_n     (rst_n),
                .sw_we     (sw_wr_en),
                .sw_val    (sw_wr_data[FLD_LSB + g*FIELD_W +: FIELD_W]),
                .upd_en    (exc_valid && !sw_wr_en && (exc_sel == SEL_W'(g))),
                .upd_flags (eff_bits),
                .val       (fval[g])
            );
        end
    endgenerate

    // Per-field disable of the selected field (reads zero in the main field).
    always_comb sel_td = fval[exc_sel][FTD_B];

    fpstat_req u_req (
        .exc_valid (exc_valid),
        .eff_bits  (eff_bits),
        .glob_td   (glob_td),
        .field_td  (sel_td),
        .fault_req (fault_req),
        .trap_req  (trap_req)
    );

    // Assemble the software-visible word; reserved bits read zero.
    always_comb begin
        sw_rd_data = '0;
        sw_rd_data[NUM_EXC-1:0] = glob_td;
        for (int k = 0; k < NUM_FIELDS; k++)
            sw_rd_data[FLD_LSB + k*FIELD_W +: FIELD_W] = fval[k];
    end

    // R3
    rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (sw_rd_data[REG_W-1:USED_W] == '0));

    // R11
    sw_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sw_wr_en) && $past(exc_valid)) |->
        (sw_rd_data[NUM_EXC-1:0] == $past(sw_wr_data[NUM_EXC-1:0])));

    // R10
    denorm_sup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && exc_denorm_suppress && glob_td != '1
            && (exc_bits & ~(NUM_EXC'(1) << DEN_IDX)) == '0) |-> !fault_req);
endmodule

// File: tb/test_fp_status_reg.sv
module test_fp_status_reg;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] WMASK = 64'h03FF_FFFF_FFFF_FFFF & ~(64'h1 << 12);

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sw_wr_en;
    logic [63:0] sw_wr_data;
    logic [63:0] sw_rd_data;
    logic        exc_valid;
    logic [1:0]  exc_sel;
    logic [5:0]  exc_bits;
    logic        exc_denorm_suppress;
    logic        fault_req;
    logic        trap_req;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [63:0] model;

    fp_status_reg i_fp_status_reg (
        .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
        .sw_rd_data(sw_rd_data), .exc_valid(exc_valid), .exc_sel(exc_sel),
        .exc_bits(exc_bits), .exc_denorm_suppress(exc_denorm_suppress),
        .fault_req(fault_req), .trap_req(trap_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int lsb_of(int sel);
        return 6 + 13*sel;
    endfunction

    task automatic sw_write(logic [63:0] d, string req);
        @(negedge clk);
        sw_wr_en = 1'b1; sw_wr_data = d;
        #1 check({req, " write raises no request"}, {62'd0, fault_req, trap_req}, 64'd0);
        @(negedge clk);
        sw_wr_en = 1'b0;
        model = d & WMASK;
        check({req, " readback"}, sw_rd_data, model);
    endtask

    task automatic report(int sel, logic [5:0] bits, logic sup, string req);
        logic [5:0] eff, en;
        logic ftd;
        eff = bits;
        if (sup) eff[1] = 1'b0;
        ftd = (sel != 0) && model[lsb_of(sel) + 6];
        en  = eff & ~model[5:0] & {6{~ftd}};
        @(negedge clk);
        exc_valid = 1'b1; exc_sel = 2'(sel); exc_bits = bits; exc_denorm_suppress = sup;
        #1;
        check({req, " fault_req"}, {63'd0, fault_req}, {63'd0, |en[2:0]});
        check({req, " trap_req"},  {63'd0, trap_req},  {63'd0, |en[5:3]});
        @(negedge clk);
        exc_valid = 1'b0; exc_bits = '0; exc_denorm_suppress = 1'b0;
        model[lsb_of(sel) + 7 +: 6] = model[lsb_of(sel) + 7 +: 6] | eff;
        check({req, " flags"}, sw_rd_data, model);
    endtask

    task automatic t_reset();
        model = 64'h3F;
        check("R1 reset word", sw_rd_data, 64'h3F);
        check("R1 no request", {62'd0, fault_req, trap_req}, 64'd0);
    endtask

    task automatic t_layout();
        sw_write(64'hFFFF_FFFF_FFFF_FFFF, "R3 R9 all ones");
        check("R8 main td reads zero", {63'd0, sw_rd_data[12]}, 64'd0);
        sw_write(64'h0000_0000_0000_0000, "R3 all zero");
        // field 2 controls: ftz=1, pc=2, rnd=3 -> 0b0111001 at bit 32
        sw_write(64'h0000_0039_0000_0000, "R3 field2 controls");
        sw_write(64'h0, "R3 clear");
    endtask

    task automatic t_reports();
        report(0, 6'b000001, 1'b0, "R4 R6 main invalid");
        report(2, 6'b001000, 1'b0, "R4 R6 field2 overflow");
        report(1, 6'b100100, 1'b0, "R4 R6 field1 zdiv+inexact");
        report(3, 6'b010000, 1'b0, "R4 R6 field3 underflow");
        report(0, 6'b000000, 1'b0, "R5 empty report keeps flags");
        report(2, 6'b000100, 1'b0, "R5 field2 accumulates");
    endtask

    task automatic t_mask_order();
        for (int i = 0; i < 6; i++) begin
            sw_write(64'h3F & ~(64'h1 << i), "R2 mask one bit enabled");
            report(0, 6'b111111, 1'b0, "R2 mask order");
        end
    endtask

    task automatic t_global_disable();
        sw_write(64'h01, "R7 disable invalid only");
        report(0, 6'b000001, 1'b0, "R7 masked invalid still flagged");
        report(0, 6'b000100, 1'b0, "R7 zdiv still faults");
    endtask

    task automatic t_field_td();
        sw_write((64'h1 << (19 + 6)) | (64'h1 << 12), "R8 set field1 td, try main td");
        check("R8 main td ignores write", {63'd0, sw_rd_data[12]}, 64'd0);
        report(1, 6'b001001, 1'b0, "R8 field1 suppressed");
        report(0, 6'b001000, 1'b0, "R8 main td no effect");
    endtask

    task automatic t_denorm();
        sw_write(64'h0, "R10 clear");
        report(3, 6'b000010, 1'b1, "R10 suppressed denormal");
        report(3, 6'b010010, 1'b1, "R10 suppress keeps underflow");
        report(3, 6'b000010, 1'b0, "R10 unsuppressed denormal");
    endtask

    task automatic t_collide();
        @(negedge clk);
        sw_wr_en = 1'b1; sw_wr_data = 64'h0000_0000_0000_0015;
        exc_valid = 1'b1; exc_sel = 2'd0; exc_bits = 6'b111111;
        @(negedge clk);
        sw_wr_en = 1'b0; exc_valid = 1'b0; exc_bits = '0;
        model = 64'h15;
        check("R11 write wins over report", sw_rd_data, model);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sw_wr_en = 1'b0; sw_wr_data = '0; exc_valid = 1'b0;
        exc_sel = '0; exc_bits = '0; exc_denorm_suppress = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_layout();
        t_reports();
        t_mask_order();
        t_global_disable();
        t_field_td();
        t_denorm();
        t_collide();
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule